// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block turns one raw centre-aligned PWM level per phase into a pair of gate drives, one for the upper and one for the lower power switch, with a blanking gap between them. While the raw level is high, the high-side gate is the one meant to be on. While it is low, the low-side gate is. A side turns on only after the raw level has held steady for twice the programmed dead-time count D. A side turns off as soon as its reference level changes, so a switch is released before its partner is closed.

Two edge placements are supported. In split mode the reference is the raw level itself. In lag mode the reference is the raw level delayed by D clocks. Take the raw level delayed by D as the timeline of the period centre. Split mode then moves each turn-off D clocks earlier than that timeline and each turn-on D clocks later. Lag mode keeps turn-off on that timeline and puts the whole 2D gap before turn-on. The dead-time count and the mode are loaded only at period boundaries. A phase that sits at 0 % or 100 % duty keeps its active side on across boundaries. When the phase enters or leaves that state, the side that turns on still waits the full gap.

Per-phase controls act at the pins without disturbing the timing core. They can force either gate off, invert the pin level of either gate, or swap which side follows the raw level.

Top module: `dtg_complementary_gen`

## Requirements
- R1: While `rst` is high, every gate pin drives its inactive level, which equals its polarity bit. `dt_cycles` and `lag_mode` are captured into the active settings during reset.
- R2: With D = 0 in split mode, the high side is active exactly when the raw sample taken two clock edges earlier was 1, and the low side is active exactly when that sample was 0. The pins are registered, two edges after the raw sample.
- R3: Split mode (`lag_mode` = 0): a side turns off 2 edges after the raw edge and turns on 2 + 2D edges after the raw edge.
- R4: Lag mode (`lag_mode` = 1): a side turns off 2 + D edges after the raw edge and turns on 2 + 3D edges after the raw edge.
- R5: In both modes, exactly 2D clocks pass with both sides inactive between one side turning off and the other turning on.
- R6: A raw level that lasts 2D samples or fewer (reference taken per mode) activates neither side. Both stay inactive.
- R7: A raw level held across period boundaries (0 % or 100 % duty) keeps its side active with no gap at the boundary. Entering or leaving that state still applies the 2D gap before the turning-on side.
- R8: `dt_cycles` and `lag_mode` take effect only on edges where `period_start` is 1. Changes at other times do not alter the pins.
- R9: `hi_off[p]` / `lo_off[p]` sampled at an edge force the matching pin to its inactive level after that edge. The timing core keeps running, so re-enabling shows the current modelled state.
- R10: Pin level = active XOR polarity bit (`hi_actlow[p]` / `lo_actlow[p]`, 1 = active-low), applied at the edge where the bit is sampled.
- R11: `swap_sides[p]` = 1 makes the high side active during raw-low and the low side active during raw-high. It takes effect at the edge where it is sampled.
- R12: The high and low sides of a phase are never active in the same cycle, in any mode, setting or transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_pwm | input | NPH | Raw centre-aligned PWM level per phase |
| period_start | input | 1 | Period boundary pulse; loads dead time and mode |
| dt_cycles | input | DW | Dead-time count D (gap is 2D clocks) |
| lag_mode | input | 1 | 0 = split edges, 1 = all of the gap before turn-on |
| swap_sides | input | NPH | Per phase: high side follows raw-low |
| hi_off | input | NPH | Per phase: force high-side gate inactive |
| lo_off | input | NPH | Per phase: force low-side gate inactive |
| hi_actlow | input | NPH | Per phase: high-side pin active-low |
| lo_actlow | input | NPH | Per phase: low-side pin active-low |
| gate_hi | output | NPH | High-side gate pins |
| gate_lo | output | NPH | Low-side gate pins |

## Verification
The blanking-gap property assumes that the active dead-time count and the swap bits have stayed unchanged for longer than the gap being measured. A swap that flips sides mid-pulse removes the gap by design. The checker therefore counts cycles since the last settings change and skips the gap check until that window has passed. The stimulus changes the dead time and mode only with a boundary pulse. It toggles swaps rarely, while the reference model pauses its exact comparison for a settling window after each boundary reload. The no-overlap and forced-off properties assume nothing about the inputs and are checked on every cycle.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic {
    EDGE_SPLIT = 1'b0,
    EDGE_LAG   = 1'b1
  } blank_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } side_pair_t;

endpackage

// File: rtl/dtg_delay_line.sv
module dtg_delay_line #(
  parameter int NPH = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] din,
  input  logic [DW-1:0]  dly,
  output logic [NPH-1:0] early,
  output logic [NPH-1:0] late
);
  localparam int DEPTH = 1 << DW;
  localparam logic [DW:0] FILL_MAX = (DW+1)'(DEPTH);

  logic [NPH-1:0] mem [DEPTH];
  logic [NPH-1:0] rd_q;
  logic [NPH-1:0] early_q;
  logic [DW-1:0]  wptr_q;
  logic [DW:0]    fill_q;
  logic           zero_q;
  logic           valid_q;

  // Storage block: write every cycle, registered read, no reset.
  always_ff @(posedge clk) begin
    mem[wptr_q] <= din;
    rd_q        <= mem[wptr_q - dly];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      fill_q  <= '0;
      early_q <= '0;
      zero_q  <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      wptr_q  <= wptr_q + 1'b1;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
      early_q <= din;
      zero_q  <= (dly == '0);
      valid_q <= (fill_q >= {1'b0, dly});
    end
  end

  assign early = early_q;
  assign late  = zero_q ? early_q : (valid_q ? rd_q : '0);

endmodule

// File: rtl/dtg_blank_gate.sv
module dtg_blank_gate #(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_lvl,
  input  logic [DW-1:0]       dly,
  output dtg_pkg::side_pair_t dem
);
  localparam int CW = DW + 1;

  logic          prev_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;
  logic [CW-1:0] thr;
  logic          ripe;

  assign thr = {dly, 1'b0};

  always_comb begin
    if (ref_lvl != prev_q)  run_nx = CW'(1);
    else if (&run_q)        run_nx = run_q;
    else                    run_nx = run_q + 1'b1;
  end

  assign ripe = (run_nx > thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      run_q  <= '0;
      dem    <= '0;
    end else begin
      prev_q <= ref_lvl;
      run_q  <= run_nx;
      dem.hi <= ref_lvl && ripe;
      dem.lo <= !ref_lvl && ripe;
    end
  end

endmodule

// File: rtl/dtg_pin_stage.sv
module dtg_pin_stage (
  input  logic                clk,
  input  logic                rst,
  input  dtg_pkg::side_pair_t dem,
  input  logic                swap,
  input  logic                hi_off,
  input  logic                lo_off,
  input  logic                hi_pol,
  input  logic                lo_pol,
  output logic                hi_pin,
  output logic                lo_pin
);
  logic hi_act;
  logic lo_act;

  always_comb begin
    hi_act = swap ? dem.lo : dem.hi;
    lo_act = swap ? dem.hi : dem.lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pin <= hi_pol;
      lo_pin <= lo_pol;
    end else begin
      hi_pin <= (hi_act && !hi_off) ^ hi_pol;
      lo_pin <= (lo_act && !lo_off) ^ lo_pol;
    end
  end

endmodule

// File: rtl/dtg_complementary_gen.sv
module dtg_complementary_gen #(
  parameter int NPH = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] raw_pwm,
  input  logic           period_start,
  input  logic [DW-1:0]  dt_cycles,
  input  logic           lag_mode,
  input  logic [NPH-1:0] swap_sides,
  input  logic [NPH-1:0] hi_off,
  input  logic [NPH-1:0] lo_off,
  input  logic [NPH-1:0] hi_actlow,
  input  logic [NPH-1:0] lo_actlow,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  import dtg_pkg::*;

  logic [DW-1:0] dt_act;
  blank_mode_e   mode_act;
  logic [NPH-1:0] early;
  logic [NPH-1:0] late;
  logic [NPH-1:0] ref_lvl;

  // Settings shadow: loaded in reset and on period boundaries only.
  always_ff @(posedge clk) begin
    if (rst || period_start) begin
      dt_act   <= dt_cycles;
      mode_act <= blank_mode_e'(lag_mode);
    end
  end

  dtg_delay_line #(.NPH(NPH), .DW(DW)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .din   (raw_pwm),
    .dly   (dt_act),
    .early (early),
    .late  (late)
  );

  assign ref_lvl = (mode_act == EDGE_LAG) ? late : early;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    side_pair_t dem;

    dtg_blank_gate #(.DW(DW)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .ref_lvl (ref_lvl[p]),
      .dly     (dt_act),
      .dem     (dem)
    );

    dtg_pin_stage u_pins (
      .clk    (clk),
      .rst    (rst),
      .dem    (dem),
      .swap   (swap_sides[p]),
      .hi_off (hi_off[p]),
      .lo_off (lo_off[p]),
      .hi_pol (hi_actlow[p]),
      .lo_pol (lo_actlow[p]),
      .hi_pin (gate_hi[p]),
      .lo_pin (gate_lo[p])
    );
  end

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int NPH = 3,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic [NPH-1:0] hi_off,
  input logic [NPH-1:0] lo_off,
  input logic [NPH-1:0] hi_actlow,
  input logic [NPH-1:0] lo_actlow,
  input logic [NPH-1:0] swap_sides,
  input logic [DW-1:0]  dt_act
);
  localparam int QW = 16;
  localparam logic [QW-1:0] QMAX = '1;

  logic [NPH-1:0] pol_hq, pol_lq, act_h, act_l, act_hq, act_lq;
  logic [QW-1:0]  quiet_h [NPH];
  logic [QW-1:0]  quiet_l [NPH];
  logic [DW+NPH-1:0] cfg_q;
  logic [QW-1:0]  cfg_age;
  logic [QW-1:0]  gap2;

  assign act_h = gate_hi ^ pol_hq;
  assign act_l = gate_lo ^ pol_lq;
  assign gap2  = {{(QW-DW-1){1'b0}}, dt_act, 1'b0};

  always_ff @(posedge clk) begin
    pol_hq <= hi_actlow;
    pol_lq <= lo_actlow;
    if (rst) begin
      act_hq  <= '0;
      act_lq  <= '0;
      cfg_q   <= {dt_act, swap_sides};
      cfg_age <= '0;
      for (int p = 0; p < NPH; p++) begin
        quiet_h[p] <= '0;
        quiet_l[p] <= '0;
      end
    end else begin
      act_hq <= act_h;
      act_lq <= act_l;
      cfg_q  <= {dt_act, swap_sides};
      if (cfg_q != {dt_act, swap_sides}) cfg_age <= '0;
      else if (cfg_age != QMAX)           cfg_age <= cfg_age + 1'b1;
      for (int p = 0; p < NPH; p++) begin
        quiet_h[p] <= act_h[p] ? '0 : ((quiet_h[p] == QMAX) ? QMAX : quiet_h[p] + 1'b1);
        quiet_l[p] <= act_l[p] ? '0 : ((quiet_l[p] == QMAX) ? QMAX : quiet_l[p] + 1'b1);
      end
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
      !(act_h[p] && act_l[p]));

    assert_hi_forced_off_R9: assert property (@(posedge clk) disable iff (rst)
      $past(hi_off[p]) |-> (gate_hi[p] == $past(hi_actlow[p])));

    assert_lo_forced_off_R9: assert property (@(posedge clk) disable iff (rst)
      $past(lo_off[p]) |-> (gate_lo[p] == $past(lo_actlow[p])));

    assert_gap_before_hi_R5: assert property (@(posedge clk) disable iff (rst)
      (act_h[p] && !act_hq[p] && (cfg_age > gap2 + 16'd4)) |-> (quiet_l[p] >= gap2));

    assert_gap_before_lo_R5: assert property (@(posedge clk) disable iff (rst)
      (act_l[p] && !act_lq[p] && (cfg_age > gap2 + 16'd4)) |-> (quiet_h[p] >= gap2));
  end

endmodule

bind dtg_complementary_gen dtg_checker #(.NPH(NPH), .DW(DW)) u_dtg_checker (
  .clk        (clk),
  .rst        (rst),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo),
  .hi_off     (hi_off),
  .lo_off     (lo_off),
  .hi_actlow  (hi_actlow),
  .lo_actlow  (lo_actlow),
  .swap_sides (swap_sides),
  .dt_act     (dt_act)
);

// File: tb/test_dtg_complementary_gen.sv
module test_dtg_complementary_gen;
  localparam int NPH = 3;
  localparam int DW  = 8;
  localparam int TM  = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic [NPH-1:0] raw = '0;
  logic           ps = 1'b0;
  logic [DW-1:0]  dt_in = 8'd4;
  logic           lag_in = 1'b0;
  logic [NPH-1:0] swap_sides = '0;
  logic [NPH-1:0] hi_off = '0;
  logic [NPH-1:0] lo_off = '0;
  logic [NPH-1:0] hi_actlow = 3'b010;
  logic [NPH-1:0] lo_actlow = 3'b100;
  logic [NPH-1:0] gate_hi, gate_lo;

  dtg_complementary_gen #(.NPH(NPH), .DW(DW)) i_dtg_complementary_gen (
    .clk(clk), .rst(rst), .raw_pwm(raw), .period_start(ps),
    .dt_cycles(dt_in), .lag_mode(lag_in), .swap_sides(swap_sides),
    .hi_off(hi_off), .lo_off(lo_off), .hi_actlow(hi_actlow),
    .lo_actlow(lo_actlow), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  int errors = 0;
  int checks = 0;
  logic [NPH-1:0] hist [1024];
  int m = -1;
  int shD = 4;
  bit shA = 1'b0;
  int settle = 60;
  bit model_on = 1'b0;
  string tag = "R3";

  function automatic logic s_at(int j, int p);
    if (j < 0) return 1'b0;
    return hist[j % 1024][p];
  endfunction

  function automatic logic e_at(int j, int p);
    return shA ? s_at(j - shD, p) : s_at(j, p);
  endfunction

  // Side demand from requirements: reference stable for 2D+1 samples.
  function automatic logic dem(int k, int p, logic want_hi);
    logic e;
    e = e_at(k, p);
    if (e != want_hi) return 1'b0;
    for (int i = 0; i <= 2 * shD; i++)
      if (e_at(k - i, p) != e) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk_bit(string r, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: got %b expected %b", r, what, m, got, exp);
    end
  endtask

  task automatic chk_int(string r, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    m++;
    hist[m % 1024] = raw;
    if (ps) begin
      if (int'(dt_in) != shD || lag_in != shA) settle = 60;
      shD = int'(dt_in);
      shA = lag_in;
    end
    for (int p = 0; p < NPH; p++) begin
      logic ah, al, eh, el;
      ah = gate_hi[p] ^ hi_actlow[p];
      al = gate_lo[p] ^ lo_actlow[p];
      chk_bit("R12", "both sides active", ah & al, 1'b0);
      if (model_on && settle == 0) begin
        eh = swap_sides[p] ? dem(m - 2, p, 1'b0) : dem(m - 2, p, 1'b1);
        el = swap_sides[p] ? dem(m - 2, p, 1'b1) : dem(m - 2, p, 1'b0);
        chk_bit(tag, "gate_hi", gate_hi[p], (eh & ~hi_off[p]) ^ hi_actlow[p]);
        chk_bit(tag, "gate_lo", gate_lo[p], (el & ~lo_off[p]) ^ lo_actlow[p]);
      end
    end
    if (settle > 0) settle--;
  endtask

  // kind: 0 random duty, 1 over-modulation mix.
  // extra: 0 none, 1 dead-time wiggle off-boundary, 2 disables, 3 polarity, 4 swap.
  task automatic run_pwm(int periods, int kind, int extra);
    int dty [NPH];
    logic [DW-1:0] base;
    base = dt_in;
    for (int per = 0; per < periods; per++) begin
      for (int p = 0; p < NPH; p++) begin
        if (kind == 1) begin
          case ($urandom_range(0, 2))
            0: dty[p] = 0;
            1: dty[p] = TM;
            default: dty[p] = int'($urandom_range(1, TM - 1));
          endcase
        end else begin
          dty[p] = int'($urandom_range(0, TM));
        end
      end
      for (int c = 0; c < 2 * TM; c++) begin
        for (int p = 0; p < NPH; p++)
          raw[p] = (c >= TM - dty[p]) && (c < TM + dty[p]);
        ps = (c == 0);
        if (extra == 1) dt_in = (c >= 10 && c < 70) ? base + 8'd3 : base;
        if (extra == 2 && $urandom_range(0, 5) == 0) begin
          hi_off[$urandom_range(0, NPH - 1)] ^= 1'b1;
          lo_off[$urandom_range(0, NPH - 1)] ^= 1'b1;
        end
        if (extra == 3 && $urandom_range(0, 5) == 0) begin
          hi_actlow[$urandom_range(0, NPH - 1)] ^= 1'b1;
          lo_actlow[$urandom_range(0, NPH - 1)] ^= 1'b1;
        end
        if (extra == 4 && $urandom_range(0, 30) == 0)
          swap_sides[$urandom_range(0, NPH - 1)] ^= 1'b1;
        step();
      end
    end
    ps = 1'b0;
  endtask

  task automatic set_cfg(int d, bit a);
    dt_in = DW'(d);
    lag_in = a;
    ps = 1'b1;
    step();
    ps = 1'b0;
  endtask

  // Directed edge timing on phase 0: low side off, high side on.
  task automatic measure(bit a, int d);
    int t_off, t_on;
    string rm;
    model_on = 1'b0;
    swap_sides = '0; hi_off = '0; lo_off = '0;
    raw = '0;
    set_cfg(d, a);
    repeat (100) step();
    raw[0] = 1'b1;
    t_off = -1; t_on = -1;
    for (int i = 0; i < 4 * d + 20; i++) begin
      step();
      if (t_off < 0 && !(gate_lo[0] ^ lo_actlow[0])) t_off = i;
      if (t_on < 0 && (gate_hi[0] ^ hi_actlow[0])) t_on = i;
    end
    rm = a ? "R4" : "R3";
    chk_int(rm, "turn-off delay", t_off, a ? 2 + d : 2);
    chk_int(rm, "turn-on delay", t_on, a ? 2 + 3 * d : 2 + 2 * d);
    chk_int("R5", "blanking length", t_on - t_off, 2 * d);
    raw[0] = 1'b0;
    t_off = -1; t_on = -1;
    for (int i = 0; i < 4 * d + 20; i++) begin
      step();
      if (t_off < 0 && !(gate_hi[0] ^ hi_actlow[0])) t_off = i;
      if (t_on < 0 && (gate_lo[0] ^ lo_actlow[0])) t_on = i;
    end
    chk_int("R5", "blanking length falling", t_on - t_off, 2 * d);
    settle = 60;
    model_on = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1357));
    // R1: reset drives inactive levels for several polarity settings.
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      for (int p = 0; p < NPH; p++) begin
        chk_bit("R1", "reset gate_hi", gate_hi[p], hi_actlow[p]);
        chk_bit("R1", "reset gate_lo", gate_lo[p], lo_actlow[p]);
      end
      hi_actlow = NPH'($urandom_range(0, 7));
      lo_actlow = NPH'($urandom_range(0, 7));
    end
    @(negedge clk);
    hi_actlow = 3'b010;
    lo_actlow = 3'b100;
    @(negedge clk);
    rst = 1'b0;
    shD = int'(dt_in); shA = lag_in; settle = 60; model_on = 1'b1;

    tag = "R3"; run_pwm(8, 0, 0);
    tag = "R4"; set_cfg(6, 1'b1); run_pwm(8, 0, 0);
    tag = "R2"; set_cfg(0, 1'b0); run_pwm(4, 0, 0);
    tag = "R7"; set_cfg(3, 1'b0); run_pwm(6, 1, 0);
    tag = "R7"; set_cfg(3, 1'b1); run_pwm(6, 1, 0);
    tag = "R6"; set_cfg(3, 1'b0);
    for (int i = 0; i < 400; i++) begin
      raw = NPH'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) raw = hist[m % 1024];
      step();
    end
    tag = "R8"; set_cfg(5, 1'b0); run_pwm(6, 0, 1);
    tag = "R9"; set_cfg(4, 1'b0); run_pwm(6, 0, 2);
    hi_off = '0; lo_off = '0;
    tag = "R10"; run_pwm(6, 0, 3);
    tag = "R11"; run_pwm(8, 0, 4);
    swap_sides = '0;
    measure(1'b0, 7);
    measure(1'b1, 7);
    measure(1'b0, 0);
    tag = "R3"; set_cfg(9, 1'b0); run_pwm(3, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule